// File: doc/BRIEF.md
# Transaction-Counting Phase Barrier

This block is a reusable synchronization barrier. Two kinds of event release it. Participating agents announce that they have reached it. A data mover reports how many bytes it has delivered. A phase of the barrier ends only when two conditions hold at once: every expected participant has arrived, and every byte announced for the phase has been reported as delivered. When a phase ends, a phase bit flips and the counts re-arm by themselves for the next round.

Software or hardware agents use it in a fixed sequence:
- One agent configures the participant count.
- A producer announces the number of bytes it expects to receive.
- Each participant arrives and keeps the returned parity token.
- The data mover reports its completed byte transfers.
- A waiter presents its token to the query port. The port reports done once the phase that issued the token has finished.

An arrival can also retire its participant, which lowers the head count for all later phases. Both counts saturate instead of wrapping. Any underflow or overflow leaves a sticky error flag.

Top module: `txn_phase_barrier`

## Requirements
- R1: After reset, `phase` is 0, `pending_arrivals` and `pending_bytes` are 0, both error flags are 0, and `query_done` is 0 for either token.
- R2: An `init_valid` cycle loads `pending_arrivals` and the participant count with `init_count`, clears `pending_bytes` and `phase`, and arms the barrier. Arrive, expect and transfer requests made before the first init have no effect on any output.
- R3: An expect request adds `expect_bytes` to `pending_bytes`, and a transfer report subtracts `xfer_bytes` from it. Both are visible on the clock edge that follows the request.
- R4: An arrive request lowers `pending_arrivals` by one on the next edge. In the cycle of the request, `arrive_token` equals the current `phase`.
- R5: The phase flips only in a cycle that carries an arrive or a transfer, and only when both counts are zero after that cycle's updates. With bytes still pending after the last arrival, `phase` holds.
- R6: On the edge where `phase` flips, `pending_arrivals` is reloaded with the participant count and `pending_bytes` becomes 0.
- R7: `query_done` is 1 exactly when the barrier is armed and `query_token` differs from `phase`. A token taken in the current phase therefore reads not-done until that phase completes.
- R8: An arrive with `arrive_drop` set also lowers the participant count by one, so every later phase needs one arrival fewer.
- R9: An arrive while `pending_arrivals` is 0 sets `err_arrive` and leaves the count at 0. A drop while the participant count is 0 also sets `err_arrive`.
- R10: A transfer larger than `pending_bytes` leaves the count at 0 and sets `err_bytes`. An expect that would exceed the count's range saturates at all ones and sets `err_bytes`.
- R11: An arrive, an expect and a transfer in the same cycle are all applied before the completion check. Bytes expected in the cycle of the last arrival therefore hold the phase open.
- R12: An init overrides every other request in its cycle. Error flags stay set across inits and clear only on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_valid | input | 1 | Load participant count and arm |
| init_count | input | CNT_W | Number of participants |
| expect_valid | input | 1 | Announce bytes to be delivered |
| expect_bytes | input | BYTE_W | Byte count to add |
| arrive_valid | input | 1 | One participant arrives |
| arrive_drop | input | 1 | With arrive: also retire the participant |
| arrive_token | output | 1 | Parity token returned to an arriving agent |
| xfer_valid | input | 1 | Data mover reports delivered bytes |
| xfer_bytes | input | BYTE_W | Delivered byte count |
| query_token | input | 1 | Token being waited on |
| query_done | output | 1 | Phase of the presented token has completed |
| phase | output | 1 | Current phase parity |
| pending_arrivals | output | CNT_W | Arrivals still missing in this phase |
| pending_bytes | output | BYTE_W | Bytes still outstanding in this phase |
| err_arrive | output | 1 | Sticky arrival or participant underflow |
| err_bytes | output | 1 | Sticky byte-count underflow or overflow |

## Verification
A wrong count inside the block shows up at the next clock edge as a mismatch on `pending_arrivals` or `pending_bytes`. The bench compares the full output set after every request, so such a mismatch is reported in that same cycle. A completion check that runs too early, or one that ignores the byte count, flips `phase` while bytes are still outstanding. It also raises `query_done` one request ahead of the reference model. A lost drop or a faulty reload stays hidden until the next phase, where it appears as a wrong reload value and a flip at the wrong arrival.

// File: rtl/txb_pkg.sv
`timescale 1ns/1ps
package txb_pkg;

    // Lifecycle of the barrier: idle until the first init, then armed.
    typedef enum logic {
        BAR_IDLE  = 1'b0,
        BAR_ARMED = 1'b1
    } bar_mode_e;

    // Sticky error bundle.
    typedef struct packed {
        logic arrive;
        logic bytes;
    } txb_fault_t;

    // A phase may end only when something that lowers a count happened
    // this cycle and both counts are zero after all of this cycle's updates.
    function automatic logic flip_ready(
        input logic armed,
        input logic touched,
        input logic arr_zero,
        input logic txn_zero
    );
        return armed && touched && arr_zero && txn_zero;
    endfunction

    // A waiter is released once the phase parity has moved past its token.
    function automatic logic token_released(
        input logic armed,
        input logic token,
        input logic cur_phase
    );
        return armed && (token != cur_phase);
    endfunction

endpackage

// File: rtl/txb_arrival_unit.sv
`timescale 1ns/1ps
module txb_arrival_unit #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_count,
    input  logic             armed,
    input  logic             arrive,
    input  logic             drop,
    input  logic             complete,
    output logic [CNT_W-1:0] arr_q,
    output logic [CNT_W-1:0] part_q,
    output logic             arr_next_zero,
    output logic             fault
);

    logic             act_arrive;
    logic             act_drop;
    logic [CNT_W-1:0] arr_after;
    logic [CNT_W-1:0] part_after;

    always_comb begin
        act_arrive = armed && !load && arrive;
        act_drop   = act_arrive && drop;
        arr_after  = arr_q;
        part_after = part_q;
        fault      = 1'b0;
        if (act_arrive) begin
            if (arr_q == '0) begin
                fault = 1'b1;
            end else begin
                arr_after = arr_q - CNT_W'(1);
            end
        end
        if (act_drop) begin
            if (part_q == '0) begin
                fault = 1'b1;
            end else begin
                part_after = part_q - CNT_W'(1);
            end
        end
    end

    assign arr_next_zero = (arr_after == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            arr_q  <= '0;
            part_q <= '0;
        end else if (load) begin
            arr_q  <= load_count;
            part_q <= load_count;
        end else begin
            part_q <= part_after;
            arr_q  <= complete ? part_after : arr_after;
        end
    end

    AST_ARRIVE_STEP: assert property (@(posedge clk) disable iff (rst)
        (act_arrive && !complete && arr_q != '0) |=> (arr_q == $past(arr_q) - CNT_W'(1))) // R4
        else $error("arrival count did not step down by one");

    AST_ARRIVE_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (act_arrive && !complete && arr_q == '0) |=> (arr_q == '0)) // R9
        else $error("arrival count wrapped");

    AST_DROP_STEP: assert property (@(posedge clk) disable iff (rst)
        (act_drop && part_q != '0) |=> (part_q == $past(part_q) - CNT_W'(1))) // R8
        else $error("participant count not lowered by drop");

endmodule

// File: rtl/txb_byte_unit.sv
`timescale 1ns/1ps
module txb_byte_unit #(
    parameter int BYTE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              armed,
    input  logic              expect_v,
    input  logic [BYTE_W-1:0] expect_bytes,
    input  logic              xfer_v,
    input  logic [BYTE_W-1:0] xfer_bytes,
    input  logic              complete,
    output logic [BYTE_W-1:0] txn_q,
    output logic              txn_next_zero,
    output logic              fault
);

    logic              act_exp;
    logic              act_xfer;
    logic [BYTE_W:0]   sum;
    logic [BYTE_W-1:0] raised;
    logic [BYTE_W-1:0] txn_after;

    always_comb begin
        act_exp   = armed && !load && expect_v;
        act_xfer  = armed && !load && xfer_v;
        // Expected bytes join the count before delivered bytes leave it.
        sum       = {1'b0, txn_q} + {1'b0, (act_exp ? expect_bytes : '0)};
        raised    = sum[BYTE_W] ? '1 : sum[BYTE_W-1:0];
        fault     = sum[BYTE_W];
        txn_after = raised;
        if (act_xfer) begin
            if (xfer_bytes > raised) begin
                txn_after = '0;
                fault     = 1'b1;
            end else begin
                txn_after = raised - xfer_bytes;
            end
        end
    end

    assign txn_next_zero = (txn_after == '0);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            txn_q <= '0;
        end else if (complete) begin
            txn_q <= '0;
        end else begin
            txn_q <= txn_after;
        end
    end

    AST_BYTES_GROW: assert property (@(posedge clk) disable iff (rst)
        (act_exp && !act_xfer && !complete) |=> (txn_q >= $past(txn_q))) // R3
        else $error("byte count shrank on an expect");

    AST_BYTES_SHRINK: assert property (@(posedge clk) disable iff (rst)
        (act_xfer && !act_exp && !complete) |=> (txn_q <= $past(txn_q))) // R10
        else $error("byte count grew on a transfer");

endmodule

// File: rtl/txb_phase_ctrl.sv
`timescale 1ns/1ps
module txb_phase_ctrl
    import txb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init_v,
    input  logic touched,
    input  logic arr_zero,
    input  logic txn_zero,
    input  logic arr_fault,
    input  logic byte_fault,
    input  logic query_token,
    output logic armed,
    output logic complete,
    output logic phase_q,
    output logic query_done,
    output logic err_arrive,
    output logic err_bytes
);

    bar_mode_e  mode_q;
    txb_fault_t err_q;

    assign armed      = (mode_q == BAR_ARMED);
    assign complete   = !init_v && flip_ready(armed, touched, arr_zero, txn_zero);
    assign query_done = token_released(armed, query_token, phase_q);
    assign err_arrive = err_q.arrive;
    assign err_bytes  = err_q.bytes;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= BAR_IDLE;
            phase_q <= 1'b0;
            err_q   <= '0;
        end else begin
            if (init_v) begin
                mode_q  <= BAR_ARMED;
                phase_q <= 1'b0;
            end else if (complete) begin
                phase_q <= !phase_q;
            end
            err_q.arrive <= err_q.arrive | arr_fault;
            err_q.bytes  <= err_q.bytes | byte_fault;
        end
    end

    AST_ERR_ARRIVE_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q.arrive |=> err_q.arrive) // R9
        else $error("arrival error flag cleared");

    AST_ERR_BYTES_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q.bytes |=> err_q.bytes) // R10
        else $error("byte error flag cleared");

    AST_FLIP_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        (!touched && !init_v) |=> (phase_q == $past(phase_q))) // R5
        else $error("phase moved without an arrive or transfer");

endmodule

// File: rtl/txn_phase_barrier.sv
`timescale 1ns/1ps
module txn_phase_barrier #(
    parameter int CNT_W  = 8,
    parameter int BYTE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_valid,
    input  logic [CNT_W-1:0]  init_count,
    input  logic              expect_valid,
    input  logic [BYTE_W-1:0] expect_bytes,
    input  logic              arrive_valid,
    input  logic              arrive_drop,
    output logic              arrive_token,
    input  logic              xfer_valid,
    input  logic [BYTE_W-1:0] xfer_bytes,
    input  logic              query_token,
    output logic              query_done,
    output logic              phase,
    output logic [CNT_W-1:0]  pending_arrivals,
    output logic [BYTE_W-1:0] pending_bytes,
    output logic              err_arrive,
    output logic              err_bytes
);

    logic             armed;
    logic             complete;
    logic             touched;
    logic             arr_zero;
    logic             txn_zero;
    logic             arr_fault;
    logic             byte_fault;
    logic [CNT_W-1:0] part_q;

    assign touched      = armed && (arrive_valid || xfer_valid);
    assign arrive_token = phase;

    txb_arrival_unit #(.CNT_W(CNT_W)) u_arrivals (
        .clk           (clk),
        .rst           (rst),
        .load          (init_valid),
        .load_count    (init_count),
        .armed         (armed),
        .arrive        (arrive_valid),
        .drop          (arrive_drop),
        .complete      (complete),
        .arr_q         (pending_arrivals),
        .part_q        (part_q),
        .arr_next_zero (arr_zero),
        .fault         (arr_fault)
    );

    txb_byte_unit #(.BYTE_W(BYTE_W)) u_bytes (
        .clk           (clk),
        .rst           (rst),
        .load          (init_valid),
        .armed         (armed),
        .expect_v      (expect_valid),
        .expect_bytes  (expect_bytes),
        .xfer_v        (xfer_valid),
        .xfer_bytes    (xfer_bytes),
        .complete      (complete),
        .txn_q         (pending_bytes),
        .txn_next_zero (txn_zero),
        .fault         (byte_fault)
    );

    txb_phase_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .init_v      (init_valid),
        .touched     (touched),
        .arr_zero    (arr_zero),
        .txn_zero    (txn_zero),
        .arr_fault   (arr_fault),
        .byte_fault  (byte_fault),
        .query_token (query_token),
        .armed       (armed),
        .complete    (complete),
        .phase_q     (phase),
        .query_done  (query_done),
        .err_arrive  (err_arrive),
        .err_bytes   (err_bytes)
    );

    AST_RELOAD_ON_FLIP: assert property (@(posedge clk) disable iff (rst)
        complete |=> (pending_bytes == '0 && pending_arrivals == part_q)) // R6
        else $error("counts not re-armed on phase flip");

    AST_BYTES_BLOCK_FLIP: assert property (@(posedge clk) disable iff (rst)
        (!init_valid && !txn_zero) |=> (phase == $past(phase))) // R5
        else $error("phase flipped with bytes outstanding");

    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        init_valid |=> (phase == 1'b0 && pending_bytes == '0)) // R12
        else $error("init did not restart the barrier");

endmodule

// File: tb/txn_phase_barrier_test.sv
`timescale 1ns/1ps
module txn_phase_barrier_test;

    localparam int CW   = 8;
    localparam int BW   = 16;
    localparam int MAXB = (1 << BW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          init_valid = 1'b0;
    logic [CW-1:0] init_count = '0;
    logic          expect_valid = 1'b0;
    logic [BW-1:0] expect_bytes = '0;
    logic          arrive_valid = 1'b0;
    logic          arrive_drop = 1'b0;
    logic          arrive_token;
    logic          xfer_valid = 1'b0;
    logic [BW-1:0] xfer_bytes = '0;
    logic          query_token = 1'b0;
    logic          query_done;
    logic          phase;
    logic [CW-1:0] pending_arrivals;
    logic [BW-1:0] pending_bytes;
    logic          err_arrive;
    logic          err_bytes;

    always #2.5 clk = ~clk;

    txn_phase_barrier #(.CNT_W(CW), .BYTE_W(BW)) uut (
        .clk(clk), .rst(rst),
        .init_valid(init_valid), .init_count(init_count),
        .expect_valid(expect_valid), .expect_bytes(expect_bytes),
        .arrive_valid(arrive_valid), .arrive_drop(arrive_drop),
        .arrive_token(arrive_token),
        .xfer_valid(xfer_valid), .xfer_bytes(xfer_bytes),
        .query_token(query_token), .query_done(query_done),
        .phase(phase), .pending_arrivals(pending_arrivals),
        .pending_bytes(pending_bytes),
        .err_arrive(err_arrive), .err_bytes(err_bytes)
    );

    typedef struct {
        bit    ph;
        int    pa;
        int    pb;
        bit    ea;
        bit    eb;
        bit    qd;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    // reference model state
    bit m_armed = 0, m_phase = 0, m_ea = 0, m_eb = 0;
    int m_arr = 0, m_part = 0, m_txn = 0;

    task automatic step(input bit ini, input int icnt, input bit ex, input int exb,
                        input bit ar, input bit dr, input bit xf, input int xb,
                        input bit qt, input string tag);
        exp_t e;
        int   a, p, t;
        bit   touched;
        @(negedge clk);
        init_valid   = ini;
        init_count   = CW'(icnt);
        expect_valid = ex;
        expect_bytes = BW'(exb);
        arrive_valid = ar;
        arrive_drop  = dr;
        xfer_valid   = xf;
        xfer_bytes   = BW'(xb);
        query_token  = qt;
        #0.5;
        if (ar && !ini && m_armed) begin
            checks++;
            if (arrive_token !== m_phase) begin
                errors++;
                $display("FAIL R4 token (%s): actual %0b expected %0b", tag, arrive_token, m_phase);
            end
        end
        if (ini) begin
            m_arr = icnt; m_part = icnt; m_txn = 0; m_phase = 0; m_armed = 1;
        end else if (m_armed) begin
            t = m_txn;
            if (ex) begin
                if (t + exb > MAXB) begin t = MAXB; m_eb = 1; end
                else t = t + exb;
            end
            if (xf) begin
                if (xb > t) begin t = 0; m_eb = 1; end
                else t = t - xb;
            end
            a = m_arr; p = m_part;
            if (ar) begin
                if (a == 0) m_ea = 1; else a = a - 1;
                if (dr) begin
                    if (p == 0) m_ea = 1; else p = p - 1;
                end
            end
            touched = ar || xf;
            if (touched && a == 0 && t == 0) begin
                m_phase = !m_phase; a = p; t = 0;
            end
            m_arr = a; m_part = p; m_txn = t;
        end
        e.ph = m_phase; e.pa = m_arr; e.pb = m_txn;
        e.ea = m_ea; e.eb = m_eb;
        e.qd = m_armed && (qt != m_phase);
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares after each edge, away from the edge itself
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (phase !== e.ph || int'(pending_arrivals) != e.pa ||
                    int'(pending_bytes) != e.pb || err_arrive !== e.ea ||
                    err_bytes !== e.eb || query_done !== e.qd) begin
                    errors++;
                    $display("FAIL %s: actual ph=%0b pa=%0d pb=%0d ea=%0b eb=%0b qd=%0b expected ph=%0b pa=%0d pb=%0d ea=%0b eb=%0b qd=%0b",
                             e.tag, phase, pending_arrivals, pending_bytes, err_arrive,
                             err_bytes, query_done, e.ph, e.pa, e.pb, e.ea, e.eb, e.qd);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        //   ini cnt ex  exb ar dr xf xb  qt
        step(0, 0, 0, 0,  0, 0, 0, 0,  1, "R1 reset state");
        step(0, 0, 1, 40, 1, 0, 1, 5,  1, "R2 requests ignored before init");
        step(1, 3, 0, 0,  0, 0, 0, 0,  0, "R2 init loads count");
        step(0, 0, 1, 64, 0, 0, 0, 0,  0, "R3 expect adds bytes");
        step(0, 0, 0, 0,  1, 0, 0, 0,  0, "R4 first arrive, R7 not done");
        step(0, 0, 0, 0,  1, 0, 0, 0,  0, "R4 second arrive");
        step(0, 0, 0, 0,  0, 0, 1, 32, 0, "R3 partial transfer");
        step(0, 0, 0, 0,  1, 0, 0, 0,  0, "R5 held open by bytes");
        step(0, 0, 0, 0,  0, 0, 1, 32, 0, "R6 flip reloads, R7 released");
        step(0, 0, 0, 0,  0, 0, 0, 0,  1, "R7 current token not done");
        step(0, 0, 1, 16, 1, 0, 0, 0,  1, "R11 expect with arrive");
        step(0, 0, 0, 0,  1, 0, 0, 0,  1, "R11 arrive");
        step(0, 0, 0, 0,  1, 0, 1, 16, 1, "R11 arrive and transfer same cycle");
        step(0, 0, 0, 0,  1, 0, 0, 0,  0, "R4 arrive new phase");
        step(0, 0, 0, 0,  1, 0, 0, 0,  0, "R4 arrive new phase");
        step(0, 0, 1, 8,  1, 0, 0, 0,  0, "R11 expect in last arrive cycle blocks");
        step(0, 0, 0, 0,  0, 0, 1, 8,  0, "R5 transfer completes phase");
        step(0, 0, 0, 0,  1, 1, 0, 0,  1, "R8 arrive with drop");
        step(0, 0, 0, 0,  1, 0, 0, 0,  1, "R8 arrive");
        step(0, 0, 0, 0,  1, 0, 0, 0,  1, "R8 flip reloads lowered count");
        step(0, 0, 0, 0,  1, 0, 0, 0,  0, "R8 one of two");
        step(0, 0, 0, 0,  1, 0, 0, 0,  0, "R8 two arrivals finish phase");
        step(0, 0, 1, 4,  1, 0, 0, 0,  0, "R3 expect and arrive");
        step(0, 0, 0, 0,  1, 0, 0, 0,  0, "R5 all arrived, bytes pending");
        step(0, 0, 0, 0,  1, 0, 0, 0,  0, "R9 arrival underflow");
        step(0, 0, 0, 0,  0, 0, 1, 10, 0, "R10 byte underflow completes");
        step(0, 0, 1, MAXB, 0, 0, 0, 0, 1, "R3 expect to full range");
        step(0, 0, 1, 10, 0, 0, 0, 0,  1, "R10 expect saturates");
        step(1, 5, 0, 0,  1, 0, 1, 3,  0, "R12 init overrides other requests");
        step(0, 0, 0, 0,  0, 0, 0, 0,  1, "R12 errors persist after init");
        @(negedge clk);
        init_valid = 0; expect_valid = 0; arrive_valid = 0; arrive_drop = 0; xfer_valid = 0;
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule